// File: doc/BRIEF.md
# Entropy Seed Health Monitor

This block watches a raw entropy bitstream that arrives one bit at a time, each bit marked by a valid strobe. It looks for two failure patterns that show a broken noise source. The first is a stuck run: too many consecutive sampled bits with the same value. The second is a sustained strict alternation (0101...). When either pattern exceeds its limit, the block raises an error level. Downstream random-number generation must halt while that level is high.

On the cycle the level rises, the block also gives a single-cycle event pulse, which a register block can latch as a sticky flag. The level stays high even if the stream becomes healthy again. Only a restart clears it. The restart input is meant to follow the peripheral enable being turned off and on again. Both run-length limits are parameters: `RUN_LIMIT` defaults to 64 and `ALT_LIMIT` defaults to 32.

Top module: `seed_health_mon`

## Requirements
- R1: After `rst_n` is deasserted, `err_level` and `err_pulse` are 0. A cycle with `restart` high clears `err_level`, `err_pulse` and all run history on the next edge, and `restart` takes priority over a valid bit in the same cycle. The first valid bit after a restart starts a fresh run.
- R2: When more than `RUN_LIMIT` consecutive valid bits share one value (all 0 or all 1), `err_level` becomes 1 at the clock edge that samples the offending bit. Exactly `RUN_LIMIT` equal bits do not raise it.
- R3: When more than `ALT_LIMIT` consecutive alternations occur, `err_level` becomes 1 at the edge that samples the offending bit. An alternation is a valid bit that differs from the previous valid bit, so `ALT_LIMIT`+2 alternating bits trip the monitor and `ALT_LIMIT`+1 bits do not.
- R4: Once set, `err_level` stays 1 until a restart, whatever further bits arrive. The internal counters saturate at limit+1 and never wrap.
- R5: `err_pulse` is 1 for exactly one cycle, in the cycle where `err_level` goes from 0 to 1. It never fires while `err_level` is already 1.
- R6: Cycles with `bit_vld` at 0 are ignored. They neither break nor extend a constant run or an alternation.
- R7: A valid bit that differs from the previous one restarts the constant-run count at 1. A valid bit equal to the previous one restarts the alternation count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Synchronous restart; follows the peripheral enable cycle |
| bit_vld | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Raw entropy bit |
| err_level | output | 1 | Current seed error level; sticky until restart |
| err_pulse | output | 1 | One-cycle event on the rising edge of `err_level` |

## Verification
The hardest cases to reach are the exact threshold boundaries. These are limit versus limit+1 equal bits, and limit+1 versus limit+2 alternating bits. They need long, precise sequences that start from a known empty history. Each table vector therefore begins with a restart and then streams a generated pattern of an exact length. The directed tests cover the remaining cases:
- invalid cycles that carry the opposite bit value inside a run;
- one broken bit that splits two just-under-limit runs;
- a restart in the middle of a run.

// File: rtl/seed_health_mon.sv
module seed_health_mon #(
  parameter int RUN_LIMIT = 64,
  parameter int ALT_LIMIT = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic bit_vld,
  input  logic bit_in,
  output logic err_level,
  output logic err_pulse
);

  localparam int RW = $clog2(RUN_LIMIT + 2);
  localparam int AW = $clog2(ALT_LIMIT + 2);
  localparam logic [RW-1:0] RUN_TOP = RW'(RUN_LIMIT + 1);
  localparam logic [RW-1:0] RUN_THR = RW'(RUN_LIMIT);
  localparam logic [AW-1:0] ALT_TOP = AW'(ALT_LIMIT + 1);
  localparam logic [AW-1:0] ALT_THR = AW'(ALT_LIMIT);

  logic [RW-1:0] run_cnt, run_nx;
  logic [AW-1:0] alt_cnt, alt_nx;
  logic          prev_bit, have_prev;
  logic          trip;

  always_comb begin
    run_nx = run_cnt;
    alt_nx = alt_cnt;
    if (bit_vld) begin
      if (!have_prev) begin
        run_nx = RW'(1);
        alt_nx = '0;
      end else if (bit_in == prev_bit) begin
        run_nx = (run_cnt == RUN_TOP) ? run_cnt : run_cnt + RW'(1);
        alt_nx = '0;
      end else begin
        run_nx = RW'(1);
        alt_nx = (alt_cnt == ALT_TOP) ? alt_cnt : alt_cnt + AW'(1);
      end
    end
  end

  assign trip = (run_nx > RUN_THR) || (alt_nx > ALT_THR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt   <= '0;
      alt_cnt   <= '0;
      prev_bit  <= 1'b0;
      have_prev <= 1'b0;
      err_level <= 1'b0;
      err_pulse <= 1'b0;
    end else if (restart) begin
      run_cnt   <= '0;
      alt_cnt   <= '0;
      prev_bit  <= 1'b0;
      have_prev <= 1'b0;
      err_level <= 1'b0;
      err_pulse <= 1'b0;
    end else begin
      run_cnt   <= run_nx;
      alt_cnt   <= alt_nx;
      if (bit_vld) begin
        prev_bit  <= bit_in;
        have_prev <= 1'b1;
      end
      err_level <= err_level | trip;
      err_pulse <= trip & ~err_level;
    end
  end

endmodule

// File: rtl/seed_health_mon_chk.sv
module seed_health_mon_chk #(
  parameter int RUN_LIMIT = 64,
  parameter int ALT_LIMIT = 32
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic                               restart,
  input logic                               bit_vld,
  input logic [$clog2(RUN_LIMIT + 2)-1:0]   run_cnt,
  input logic [$clog2(ALT_LIMIT + 2)-1:0]   alt_cnt,
  input logic                               err_level,
  input logic                               err_pulse
);

  p_restart_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!err_level && !err_pulse && run_cnt == 0 && alt_cnt == 0));

  p_rise_has_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_level) |-> (int'(run_cnt) > RUN_LIMIT || int'(alt_cnt) > ALT_LIMIT));

  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (err_level && !restart) |=> err_level);

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(run_cnt) <= RUN_LIMIT + 1) && (int'(alt_cnt) <= ALT_LIMIT + 1));

  p_pulse_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_level) |-> err_pulse);

  p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |=> !err_pulse);

  p_pulse_with_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> err_level);

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_vld && !restart) |=> ($stable(run_cnt) && $stable(alt_cnt)));

endmodule

bind seed_health_mon seed_health_mon_chk #(
  .RUN_LIMIT(RUN_LIMIT),
  .ALT_LIMIT(ALT_LIMIT)
) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .restart(restart),
  .bit_vld(bit_vld),
  .run_cnt(run_cnt),
  .alt_cnt(alt_cnt),
  .err_level(err_level),
  .err_pulse(err_pulse)
);

// File: tb/seed_health_mon_test.sv
module seed_health_mon_test;
  localparam int PERIOD = 10;
  localparam int RUNL = 64;
  localparam int ALTL = 32;

  // kind: 0 all zero, 1 all one, 2 alternating from 0, 3 alternating from 1
  localparam int NV = 10;
  localparam int V_KIND [NV] = '{0, 0, 1, 1, 2, 2, 3, 3, 1, 2};
  localparam int V_LEN  [NV] = '{RUNL, RUNL+1, RUNL, RUNL+1, ALTL+1, ALTL+2,
                                 ALTL+1, ALTL+2, 300, 200};
  localparam int V_EXP  [NV] = '{0, 1, 0, 1, 0, 1, 0, 1, 1, 1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic restart = 1'b0;
  logic bit_vld = 1'b0;
  logic bit_in = 1'b0;
  logic err_level, err_pulse;
  int tests = 0, fails = 0, pulses = 0;

  seed_health_mon #(.RUN_LIMIT(RUNL), .ALT_LIMIT(ALTL)) uut (
    .clk(clk), .rst_n(rst_n), .restart(restart), .bit_vld(bit_vld),
    .bit_in(bit_in), .err_level(err_level), .err_pulse(err_pulse));

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(logic v, logic b);
    bit_vld = v;
    bit_in  = b;
    @(posedge clk);
    #1;
    if (err_pulse) pulses++;
    bit_vld = 1'b0;
  endtask

  task automatic do_restart();
    restart = 1'b1;
    bit_vld = 1'b1;
    bit_in  = 1'b1;
    @(posedge clk);
    #1;
    restart = 1'b0;
    bit_vld = 1'b0;
    pulses  = 0;
  endtask

  task automatic stream(int kind, int len);
    for (int i = 0; i < len; i++) begin
      case (kind)
        0: drive(1'b1, 1'b0);
        1: drive(1'b1, 1'b1);
        2: drive(1'b1, i[0]);
        default: drive(1'b1, ~i[0]);
      endcase
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset level", int'(err_level), 0);
    chk("R1 reset pulse", int'(err_pulse), 0);
    rst_n = 1'b1;
    drive(1'b0, 1'b0);
    chk("R1 idle after reset", int'(err_level), 0);

    // table walk: boundaries of constant runs and alternations
    for (int v = 0; v < NV; v++) begin
      do_restart();
      chk("R1 restart clears level", int'(err_level), 0);
      stream(V_KIND[v], V_LEN[v]);
      drive(1'b0, 1'b0);
      chk(V_KIND[v] < 2 ? "R2 run boundary" : "R3 alternation boundary",
          int'(err_level), V_EXP[v]);
      chk("R5 pulse count", pulses, V_EXP[v]);
    end

    // R4: sticky after healthy stream
    do_restart();
    stream(0, RUNL + 1);
    for (int i = 0; i < 60; i++) drive(1'b1, (i % 3) == 0);
    chk("R4 level sticky", int'(err_level), 1);
    chk("R5 single pulse", pulses, 1);
    do_restart();
    chk("R4 restart clears", int'(err_level), 0);
    chk("R1 pulse cleared", int'(err_pulse), 0);

    // R6: invalid cycles carrying the opposite value inside a run
    do_restart();
    stream(1, 40);
    for (int i = 0; i < 10; i++) drive(1'b0, 1'b0);
    stream(1, 24);
    chk("R6 gaps ignored no trip at 64", int'(err_level), 0);
    drive(1'b1, 1'b0);
    drive(1'b0, 1'b1);
    chk("R6 zero breaks run", int'(err_level), 0);
    do_restart();
    stream(1, 40);
    for (int i = 0; i < 10; i++) drive(1'b0, 1'b0);
    stream(1, 25);
    chk("R6 gaps do not break run", int'(err_level), 1);

    // R6: invalid cycles inside an alternation
    do_restart();
    for (int i = 0; i < ALTL + 2; i++) begin
      drive(1'b1, i[0]);
      drive(1'b0, i[0]);
    end
    chk("R6 gaps inside alternation", int'(err_level), 1);

    // R7: one broken bit splits constant runs
    do_restart();
    stream(1, RUNL);
    drive(1'b1, 1'b0);
    stream(1, RUNL);
    chk("R7 run count reset by differing bit", int'(err_level), 0);

    // R7: a repeated bit splits alternations
    do_restart();
    stream(2, ALTL + 1);
    drive(1'b1, 1'b0);
    stream(2, ALTL + 1);
    chk("R7 alternation reset by equal bit", int'(err_level), 0);
    chk("R7 no pulse", pulses, 0);

    // R1: restart in the middle of a run forgets history
    do_restart();
    stream(1, 60);
    do_restart();
    stream(1, 10);
    chk("R1 mid-run restart", int'(err_level), 0);
    drive(1'b0, 1'b0);
    chk("R1 pulse low", int'(err_pulse), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule